// File: doc/BRIEF.md
# Transactional Versioning Line Buffer

This block is a small per-core buffer that sits beside the regular data cache and holds the state of the memory transaction in flight. Each line keeps two copies of its word. The committed copy is the value as it stood before the transaction. The speculative copy is what the transaction has written. Each line also carries a read mark and a write mark. The core opens a transaction in one of two default modes. Each access then carries two override flags that can force it to be transactional or to be regular. The buffer serves transactional loads and stores. It also serves regular accesses that hit one of its lines. A regular access that misses reports a miss so that the regular cache can serve it.

Coherence snoops from other cores are compared against the lines. A snoop of any kind that hits a written line aborts the transaction. A write or invalidate snoop that hits a line that was only read also aborts it. A commit promotes every speculative copy in a single cycle. An abort restores every speculative copy from the committed copy in a single cycle. A transactional access that misses in a set whose ways are all marked aborts with an overflow cause, so that software can take over. A conflict abort also reports the handler address that was captured when the transaction began.

Top module: `tvb_buffer`

## Requirements
- R1: After reset the buffer reports no transaction, not busy, abort cause 0, and no response.
- R2: An access is transactional only while a transaction is active. In that case it is transactional when `acc_force_tx` is set, or when the transaction opened in begin-all mode (`tx_begin_select`=0) and `acc_force_reg` is clear. Begin-select mode is `tx_begin_select`=1. `acc_force_tx` wins over `acc_force_reg`. `rsp_tx` reports the decision one cycle after the access.
- R3: A transactional store leaves the committed copy untouched. A later transactional load of that line returns the stored value. A regular load of it returns the value held before the transaction. On a miss the committed copy is taken from `acc_fill`.
- R4: A commit raises `busy` for exactly one cycle, then pulses `commit_done`. After that, every line written in the transaction reads its speculative value through regular loads.
- R5: An explicit abort raises `busy` for one cycle, then pulses `abort_done` with cause 3. Written lines read their pre-transaction values afterwards.
- R6: A snoop that hits a written line, or a write/invalidate snoop (`snp_kill`=1) that hits a line that was only read, aborts with cause 1. It pulses `redirect_valid` with `redirect_addr` equal to the handler given at begin. A read snoop of a line that was only read has no effect.
- R7: A transactional access that misses in a set whose ways all carry marks aborts with cause 2 and gives no response. No redirect follows. Lines allocated earlier in the transaction remain and hold their committed data.
- R8: An access presented while `busy` is high gives no response and changes no line. A begin request during an active transaction is ignored and the mode stays as it was.
- R9: A regular access that misses responds with `rsp_hit`=0 and data 0, and it allocates nothing. A regular load that hits returns the current committed value.
- R10: A write/invalidate snoop that hits an unmarked line removes that line.
- R11: When several endings arrive in the same cycle, the priority is conflict, then overflow, then explicit abort, then commit. An access in that same cycle is dropped.
- R12: `abort_cause` keeps its value after an abort until the next transaction begins, and the begin clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Open a transaction |
| tx_begin_select | input | 1 | 0 = begin-all default, 1 = begin-select default |
| tx_handler | input | PCW | Conflict handler address captured at begin |
| tx_commit | input | 1 | Commit request |
| tx_abort | input | 1 | Explicit abort request |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_force_tx | input | 1 | Force the access transactional |
| acc_force_reg | input | 1 | Force the access regular |
| acc_addr | input | AW | Word address, low bits select the set |
| acc_wdata | input | DW | Store data |
| acc_fill | input | DW | Current committed word from the regular path, used on a miss |
| snp_valid | input | 1 | Incoming snoop strobe |
| snp_kill | input | 1 | 1 = remote write or invalidate, 0 = remote read |
| snp_addr | input | AW | Snooped word address |
| tx_active | output | 1 | Transaction open |
| busy | output | 1 | Commit or abort in progress |
| rsp_valid | output | 1 | Access response |
| rsp_hit | output | 1 | Served by this buffer |
| rsp_tx | output | 1 | Access was treated as transactional |
| rsp_data | output | DW | Load data or echoed store data |
| commit_done | output | 1 | Commit completed (pulse) |
| abort_done | output | 1 | Abort completed (pulse) |
| abort_cause | output | 2 | 0 none, 1 conflict, 2 overflow, 3 explicit |
| redirect_valid | output | 1 | Branch to the conflict handler (pulse) |
| redirect_addr | output | PCW | Conflict handler address |

## Verification
The bound checker watches, on every cycle, the behaviour that can be judged from the control outputs alone. Busy never lasts beyond one cycle and never overlaps an open transaction. No response follows a busy cycle. Commit and abort pulses are exclusive and come only out of a busy cycle. A redirect appears only with a conflict abort and never with an overflow. A transactional response requires an open transaction. The version behaviour can only be shown by the bench's directed scenarios, because it requires a read issued after the right sequence. These scenarios cover which copy a load returns before and after commit or abort, which snoops count as conflicts, overflow in a full set, the drop of accesses during busy, and the priority among endings arriving in the same cycle.

// File: rtl/tvb_pkg.sv
package tvb_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_OVERFLOW = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } abort_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_FINISH = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tvb_mode_decode.sv
module tvb_mode_decode (
  input  logic in_tx,
  input  logic mode_select,
  input  logic force_tx,
  input  logic force_reg,
  output logic is_tx
);
  // force_tx dominates; otherwise the begin mode supplies the default
  always_comb begin
    if (!in_tx)         is_tx = 1'b0;
    else if (force_tx)  is_tx = 1'b1;
    else if (force_reg) is_tx = 1'b0;
    else                is_tx = ~mode_select;
  end
endmodule

// File: rtl/tvb_set_lookup.sv
module tvb_set_lookup #(
  parameter int WAYS = 2,
  parameter int TAGW = 14,
  parameter int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]           valid,
  input  logic [WAYS-1:0][TAGW-1:0] tags,
  input  logic [WAYS-1:0]           rdm,
  input  logic [WAYS-1:0]           wrm,
  input  logic [TAGW-1:0]           req_tag,
  output logic                      hit,
  output logic [WW-1:0]             hit_way,
  output logic                      hit_rd,
  output logic                      hit_wr
);
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    hit_rd  = 1'b0;
    hit_wr  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && valid[w] && (tags[w] == req_tag)) begin
        hit     = 1'b1;
        hit_way = WW'(w);
        hit_rd  = rdm[w];
        hit_wr  = wrm[w];
      end
    end
  end
endmodule

// File: rtl/tvb_victim.sv
module tvb_victim #(
  parameter int WAYS = 2,
  parameter int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] rdm,
  input  logic [WAYS-1:0] wrm,
  output logic            has_room,
  output logic [WW-1:0]   victim_way
);
  logic          free_found, spare_found;
  logic [WW-1:0] free_way, spare_way;

  // an empty way is preferred, then an unmarked valid way; marked ways stay
  always_comb begin
    free_found  = 1'b0;
    spare_found = 1'b0;
    free_way    = '0;
    spare_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !valid[w]) begin
        free_found = 1'b1;
        free_way   = WW'(w);
      end
      if (!spare_found && valid[w] && !rdm[w] && !wrm[w]) begin
        spare_found = 1'b1;
        spare_way   = WW'(w);
      end
    end
    has_room   = free_found | spare_found;
    victim_way = free_found ? free_way : spare_way;
  end
endmodule

// File: rtl/tvb_ctrl.sv
module tvb_ctrl
  import tvb_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           begin_req,
  input  logic           begin_select,
  input  logic [PCW-1:0] begin_handler,
  input  logic           commit_req,
  input  logic           abort_req,
  input  logic           conflict,
  input  logic           overflow,
  output logic           tx_active,
  output logic           mode_select,
  output logic           busy,
  output logic           end_event,
  output logic           flash_commit,
  output logic           flash_abort,
  output logic           commit_done,
  output logic           abort_done,
  output logic [1:0]     abort_cause,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_addr
);
  tx_state_e    state_q;
  abort_cause_e next_cause, pend_cause_q, cause_q;
  logic         mode_q, pend_commit_q;
  logic         commit_q, abort_q, redirect_q;
  logic [PCW-1:0] handler_q;

  // fixed priority among endings arriving together
  always_comb begin
    if (conflict)       next_cause = CAUSE_CONFLICT;
    else if (overflow)  next_cause = CAUSE_OVERFLOW;
    else if (abort_req) next_cause = CAUSE_EXPLICIT;
    else                next_cause = CAUSE_NONE;
  end

  assign end_event = (state_q == ST_ACTIVE) &
                     (conflict | overflow | abort_req | commit_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      mode_q        <= 1'b0;
      handler_q     <= '0;
      pend_commit_q <= 1'b0;
      pend_cause_q  <= CAUSE_NONE;
      cause_q       <= CAUSE_NONE;
      commit_q      <= 1'b0;
      abort_q       <= 1'b0;
      redirect_q    <= 1'b0;
    end else begin
      commit_q   <= 1'b0;
      abort_q    <= 1'b0;
      redirect_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (begin_req) begin
            state_q   <= ST_ACTIVE;
            mode_q    <= begin_select;
            handler_q <= begin_handler;
            cause_q   <= CAUSE_NONE;
          end
        end
        ST_ACTIVE: begin
          if (end_event) begin
            state_q       <= ST_FINISH;
            pend_commit_q <= (next_cause == CAUSE_NONE);
            pend_cause_q  <= next_cause;
          end
        end
        ST_FINISH: begin
          state_q    <= ST_IDLE;
          commit_q   <= pend_commit_q;
          abort_q    <= ~pend_commit_q;
          redirect_q <= (pend_cause_q == CAUSE_CONFLICT);
          if (!pend_commit_q) cause_q <= pend_cause_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_active      = (state_q == ST_ACTIVE);
  assign busy           = (state_q == ST_FINISH);
  assign mode_select    = mode_q;
  assign flash_commit   = busy & pend_commit_q;
  assign flash_abort    = busy & ~pend_commit_q;
  assign commit_done    = commit_q;
  assign abort_done     = abort_q;
  assign abort_cause    = cause_q;
  assign redirect_valid = redirect_q;
  assign redirect_addr  = handler_q;
endmodule

// File: rtl/tvb_buffer.sv
module tvb_buffer #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int PCW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_begin,
  input  logic           tx_begin_select,
  input  logic [PCW-1:0] tx_handler,
  input  logic           tx_commit,
  input  logic           tx_abort,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic           acc_force_tx,
  input  logic           acc_force_reg,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_wdata,
  input  logic [DW-1:0]  acc_fill,
  input  logic           snp_valid,
  input  logic           snp_kill,
  input  logic [AW-1:0]  snp_addr,
  output logic           tx_active,
  output logic           busy,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic           rsp_tx,
  output logic [DW-1:0]  rsp_data,
  output logic           commit_done,
  output logic           abort_done,
  output logic [1:0]     abort_cause,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_addr
);
  // SETS and WAYS are powers of two, WAYS >= 2
  localparam int IDXW  = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int TAGW  = AW - IDXW;
  localparam int LW    = IDXW + WW;
  localparam int LINES = SETS * WAYS;

  logic [LINES-1:0] ln_valid, ln_rd, ln_wr;
  logic [TAGW-1:0]  ln_tag [LINES];
  logic [DW-1:0]    ln_old [LINES];
  logic [DW-1:0]    ln_new [LINES];

  logic [IDXW-1:0] acc_set, snp_set;
  logic [TAGW-1:0] acc_tag, snp_tag;
  assign acc_set = acc_addr[IDXW-1:0];
  assign acc_tag = acc_addr[AW-1:IDXW];
  assign snp_set = snp_addr[IDXW-1:0];
  assign snp_tag = snp_addr[AW-1:IDXW];

  logic [WAYS-1:0]           a_valid, a_rdm, a_wrm, s_valid, s_rdm, s_wrm;
  logic [WAYS-1:0][TAGW-1:0] a_tags, s_tags;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WW-1:0] WSEL = WW'(w);
    assign a_valid[w] = ln_valid[{acc_set, WSEL}];
    assign a_rdm[w]   = ln_rd[{acc_set, WSEL}];
    assign a_wrm[w]   = ln_wr[{acc_set, WSEL}];
    assign a_tags[w]  = ln_tag[{acc_set, WSEL}];
    assign s_valid[w] = ln_valid[{snp_set, WSEL}];
    assign s_rdm[w]   = ln_rd[{snp_set, WSEL}];
    assign s_wrm[w]   = ln_wr[{snp_set, WSEL}];
    assign s_tags[w]  = ln_tag[{snp_set, WSEL}];
  end

  logic          a_hit, a_rd, a_wr, a_room, s_hit, s_rd, s_wr;
  logic [WW-1:0] a_way, a_victim, s_way;

  tvb_set_lookup #(.WAYS(WAYS), .TAGW(TAGW), .WW(WW)) u_acc_lookup (
    .valid(a_valid), .tags(a_tags), .rdm(a_rdm), .wrm(a_wrm),
    .req_tag(acc_tag), .hit(a_hit), .hit_way(a_way),
    .hit_rd(a_rd), .hit_wr(a_wr)
  );

  tvb_set_lookup #(.WAYS(WAYS), .TAGW(TAGW), .WW(WW)) u_snp_lookup (
    .valid(s_valid), .tags(s_tags), .rdm(s_rdm), .wrm(s_wrm),
    .req_tag(snp_tag), .hit(s_hit), .hit_way(s_way),
    .hit_rd(s_rd), .hit_wr(s_wr)
  );

  tvb_victim #(.WAYS(WAYS), .WW(WW)) u_victim (
    .valid(a_valid), .rdm(a_rdm), .wrm(a_wrm),
    .has_room(a_room), .victim_way(a_victim)
  );

  logic mode_sel, is_tx, end_event, flash_commit, flash_abort;
  logic conflict, overflow, acc_do;

  tvb_mode_decode u_decode (
    .in_tx(tx_active), .mode_select(mode_sel),
    .force_tx(acc_force_tx), .force_reg(acc_force_reg), .is_tx(is_tx)
  );

  assign conflict = tx_active & snp_valid & s_hit & (s_wr | (s_rd & snp_kill));
  assign overflow = tx_active & acc_valid & is_tx & ~a_hit & ~a_room;
  assign acc_do   = acc_valid & ~busy & ~end_event;

  tvb_ctrl #(.PCW(PCW)) u_ctrl (
    .clk(clk), .rst(rst),
    .begin_req(tx_begin), .begin_select(tx_begin_select),
    .begin_handler(tx_handler), .commit_req(tx_commit), .abort_req(tx_abort),
    .conflict(conflict), .overflow(overflow),
    .tx_active(tx_active), .mode_select(mode_sel), .busy(busy),
    .end_event(end_event), .flash_commit(flash_commit),
    .flash_abort(flash_abort), .commit_done(commit_done),
    .abort_done(abort_done), .abort_cause(abort_cause),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  logic [LW-1:0] hit_idx, alloc_idx, snp_idx;
  assign hit_idx   = {acc_set, a_way};
  assign alloc_idx = {acc_set, a_victim};
  assign snp_idx   = {snp_set, s_way};

  // line payload: no reset, flash promote/restore of written lines
  always_ff @(posedge clk) begin
    if (flash_commit) begin
      for (int l = 0; l < LINES; l++)
        if (ln_wr[l]) ln_old[l] <= ln_new[l];
    end else if (flash_abort) begin
      for (int l = 0; l < LINES; l++)
        if (ln_wr[l]) ln_new[l] <= ln_old[l];
    end else if (acc_do) begin
      if (is_tx) begin
        if (a_hit) begin
          if (acc_write) ln_new[hit_idx] <= acc_wdata;
        end else begin
          ln_tag[alloc_idx] <= acc_tag;
          ln_old[alloc_idx] <= acc_fill;
          ln_new[alloc_idx] <= acc_write ? acc_wdata : acc_fill;
        end
      end else if (acc_write && a_hit) begin
        ln_old[hit_idx] <= acc_wdata;
        if (!a_wr) ln_new[hit_idx] <= acc_wdata;
      end
    end
  end

  // line validity and transactional marks
  always_ff @(posedge clk) begin
    if (rst) begin
      ln_valid <= '0;
      ln_rd    <= '0;
      ln_wr    <= '0;
    end else begin
      if (flash_commit || flash_abort) begin
        ln_rd <= '0;
        ln_wr <= '0;
      end else if (acc_do && is_tx) begin
        if (a_hit) begin
          ln_rd[hit_idx] <= a_rd | ~acc_write;
          ln_wr[hit_idx] <= a_wr | acc_write;
        end else begin
          ln_valid[alloc_idx] <= 1'b1;
          ln_rd[alloc_idx]    <= ~acc_write;
          ln_wr[alloc_idx]    <= acc_write;
        end
      end
      if (snp_valid && snp_kill && s_hit) begin
        ln_valid[snp_idx] <= 1'b0;
        ln_rd[snp_idx]    <= 1'b0;
        ln_wr[snp_idx]    <= 1'b0;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_tx    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_do;
      rsp_tx    <= acc_do & is_tx;
      rsp_hit   <= acc_do & (is_tx | a_hit);
      if (!acc_do)        rsp_data <= '0;
      else if (acc_write) rsp_data <= acc_wdata;
      else if (is_tx)     rsp_data <= a_hit ? ln_new[hit_idx] : acc_fill;
      else                rsp_data <= a_hit ? ln_old[hit_idx] : '0;
    end
  end
endmodule

// File: rtl/tvb_buffer_chk.sv
module tvb_buffer_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_active,
  input logic       busy,
  input logic       rsp_valid,
  input logic       rsp_tx,
  input logic       commit_done,
  input logic       abort_done,
  input logic [1:0] abort_cause,
  input logic       redirect_valid
);
  p_busy_single_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_finish_from_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_done || abort_done) |-> $past(busy));

  p_finish_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(commit_done && abort_done));

  p_redirect_conflict_r6: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (abort_done && abort_cause == 2'd1));

  p_no_overflow_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    (abort_done && abort_cause == 2'd2) |-> !redirect_valid);

  p_no_rsp_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_valid);

  p_busy_not_active_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && tx_active));

  p_tx_rsp_needs_tx_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_tx) |-> $past(tx_active));
endmodule

bind tvb_buffer tvb_buffer_chk u_chk (
  .clk(clk), .rst(rst), .tx_active(tx_active), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_tx(rsp_tx), .commit_done(commit_done),
  .abort_done(abort_done), .abort_cause(abort_cause),
  .redirect_valid(redirect_valid)
);

// File: tb/tvb_buffer_test.sv
module tvb_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        tx_begin = 0, tx_begin_select = 0, tx_commit = 0, tx_abort = 0;
  logic [31:0] tx_handler = '0;
  logic        acc_valid = 0, acc_write = 0, acc_force_tx = 0, acc_force_reg = 0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_fill = '0;
  logic        snp_valid = 0, snp_kill = 0;
  logic [15:0] snp_addr = '0;
  logic        tx_active, busy, rsp_valid, rsp_hit, rsp_tx;
  logic [31:0] rsp_data, redirect_addr;
  logic        commit_done, abort_done, redirect_valid;
  logic [1:0]  abort_cause;

  tvb_buffer uut (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_begin_select(tx_begin_select),
    .tx_handler(tx_handler), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_force_tx(acc_force_tx),
    .acc_force_reg(acc_force_reg), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_fill(acc_fill), .snp_valid(snp_valid), .snp_kill(snp_kill),
    .snp_addr(snp_addr), .tx_active(tx_active), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tx(rsp_tx),
    .rsp_data(rsp_data), .commit_done(commit_done), .abort_done(abort_done),
    .abort_cause(abort_cause), .redirect_valid(redirect_valid),
    .redirect_addr(redirect_addr)
  );

  int checks = 0;
  int errors = 0;
  logic        r_valid, r_hit, r_tx;
  logic [31:0] r_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic ftx, input logic freg,
                        input logic [15:0] a, input logic [31:0] wd,
                        input logic [31:0] fill);
    acc_valid = 1; acc_write = wr; acc_force_tx = ftx; acc_force_reg = freg;
    acc_addr = a; acc_wdata = wd; acc_fill = fill;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_force_tx = 0; acc_force_reg = 0;
    r_valid = rsp_valid; r_hit = rsp_hit; r_tx = rsp_tx; r_data = rsp_data;
  endtask

  task automatic start_tx(input logic sel, input logic [31:0] h);
    tx_begin = 1; tx_begin_select = sel; tx_handler = h;
    @(negedge clk);
    tx_begin = 0; tx_begin_select = 0;
  endtask

  task automatic finish(input logic do_commit, input string req);
    if (do_commit) tx_commit = 1; else tx_abort = 1;
    @(negedge clk);
    tx_commit = 0; tx_abort = 0;
    chk({req, " busy during finish"}, 32'(busy), 1);
    @(negedge clk);
    chk({req, " busy released"}, 32'(busy), 0);
    chk({req, " commit pulse"}, 32'(commit_done), 32'(do_commit));
    chk({req, " abort pulse"}, 32'(abort_done), 32'(!do_commit));
  endtask

  task automatic snoop(input logic kill, input logic [15:0] a);
    snp_valid = 1; snp_kill = kill; snp_addr = a;
    @(negedge clk);
    snp_valid = 0; snp_kill = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_active", 32'(tx_active), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 cause", 32'(abort_cause), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_mode();
    access(0, 1, 0, 16'h0010, 0, 32'h1);
    chk("R2 force_tx outside tx is regular", 32'(r_tx), 0);
    start_tx(0, 32'h0);
    access(0, 0, 0, 16'h0020, 0, 32'h0000AAAA);
    chk("R2 begin-all default tx", 32'(r_tx), 1);
    chk("R3 tx miss returns fill", r_data, 32'h0000AAAA);
    access(0, 0, 1, 16'h0024, 0, 32'h2);
    chk("R2 force_reg in begin-all", 32'(r_tx), 0);
    access(0, 1, 1, 16'h0020, 0, 32'h3);
    chk("R2 force_tx beats force_reg", 32'(r_tx), 1);
    finish(0, "R5");
    start_tx(1, 32'h0);
    access(0, 0, 0, 16'h0028, 0, 32'h4);
    chk("R2 begin-select default regular", 32'(r_tx), 0);
    access(0, 1, 0, 16'h002C, 0, 32'h5);
    chk("R2 begin-select force_tx", 32'(r_tx), 1);
    finish(0, "R5");
  endtask

  task automatic t_versions();
    start_tx(0, 32'h0);
    access(1, 0, 0, 16'h0041, 32'h00001111, 32'h00000055);
    access(0, 0, 0, 16'h0041, 0, 32'hDEAD0000);
    chk("R3 tx load sees new copy", r_data, 32'h00001111);
    access(0, 0, 1, 16'h0041, 0, 32'hDEAD0000);
    chk("R3 regular load hit", 32'(r_hit), 1);
    chk("R3 regular load sees old copy", r_data, 32'h00000055);
    finish(1, "R4");
    access(0, 0, 0, 16'h0041, 0, 32'hDEAD0000);
    chk("R4 committed value current", r_data, 32'h00001111);
  endtask

  task automatic t_abort();
    start_tx(0, 32'h0);
    access(1, 0, 0, 16'h0042, 32'h00002222, 32'h00000077);
    finish(0, "R5");
    chk("R5 explicit cause", 32'(abort_cause), 3);
    chk("R5 no redirect", 32'(redirect_valid), 0);
    access(0, 0, 0, 16'h0042, 0, 32'hDEAD0000);
    chk("R5 old copy restored", r_data, 32'h00000077);
    @(negedge clk);
    chk("R12 cause held while idle", 32'(abort_cause), 3);
  endtask

  task automatic t_conflict();
    start_tx(1, 32'h12340000);
    chk("R12 begin clears cause", 32'(abort_cause), 0);
    access(0, 1, 0, 16'h0043, 0, 32'h9);
    snoop(0, 16'h0043);
    chk("R6 read snoop on read line: no busy", 32'(busy), 0);
    @(negedge clk);
    chk("R6 read snoop on read line: still active", 32'(tx_active), 1);
    snoop(1, 16'h0043);
    chk("R6 kill snoop on read line: busy", 32'(busy), 1);
    @(negedge clk);
    chk("R6 abort pulse", 32'(abort_done), 1);
    chk("R6 conflict cause", 32'(abort_cause), 1);
    chk("R6 redirect", 32'(redirect_valid), 1);
    chk("R6 handler", redirect_addr, 32'h12340000);
    start_tx(0, 32'h00005678);
    access(1, 0, 0, 16'h0046, 32'h66, 32'h6);
    snoop(0, 16'h0046);
    chk("R6 read snoop on written line: busy", 32'(busy), 1);
    @(negedge clk);
    chk("R6 written line cause", 32'(abort_cause), 1);
    chk("R6 written line handler", redirect_addr, 32'h00005678);
  endtask

  task automatic t_overflow();
    start_tx(0, 32'h0);
    access(0, 0, 0, 16'h0003, 0, 32'h00000333);
    access(0, 0, 0, 16'h0007, 0, 32'h00000777);
    access(0, 0, 0, 16'h000B, 0, 32'h00000BBB);
    chk("R7 no response on overflow", 32'(r_valid), 0);
    chk("R7 busy after overflow", 32'(busy), 1);
    @(negedge clk);
    chk("R7 overflow cause", 32'(abort_cause), 2);
    chk("R7 no redirect", 32'(redirect_valid), 0);
    access(0, 0, 0, 16'h0003, 0, 32'hDEAD0000);
    chk("R7 earlier line kept", r_data, 32'h00000333);
  endtask

  task automatic t_busy();
    start_tx(0, 32'h0);
    start_tx(1, 32'h0);
    access(0, 0, 0, 16'h0061, 0, 32'h61);
    chk("R8 second begin ignored, mode kept", 32'(r_tx), 1);
    tx_commit = 1;
    @(negedge clk);
    tx_commit = 0;
    access(1, 0, 0, 16'h0020, 32'h00000BAD, 32'h0);
    chk("R8 access during busy dropped", 32'(r_valid), 0);
    access(0, 0, 0, 16'h0020, 0, 32'hDEAD0000);
    chk("R8 line untouched by dropped access", r_data, 32'h0000AAAA);
  endtask

  task automatic t_regular();
    access(0, 0, 0, 16'h0060, 0, 32'h5555);
    chk("R9 regular miss hit flag", 32'(r_hit), 0);
    chk("R9 regular miss data", r_data, 32'h0);
    access(0, 0, 0, 16'h0060, 0, 32'h5555);
    chk("R9 regular miss allocates nothing", 32'(r_hit), 0);
    access(0, 0, 0, 16'h0041, 0, 32'h0);
    chk("R9 regular hit", r_data, 32'h00001111);
    snoop(1, 16'h0041);
    access(0, 0, 0, 16'h0041, 0, 32'h0);
    chk("R10 kill snoop removed line", 32'(r_hit), 0);
  endtask

  task automatic t_priority();
    start_tx(0, 32'hCAFE0000);
    access(0, 0, 0, 16'h0005, 0, 32'h5);
    snp_valid = 1; snp_kill = 1; snp_addr = 16'h0005;
    tx_abort = 1; tx_commit = 1;
    acc_valid = 1; acc_write = 1; acc_addr = 16'h0009; acc_wdata = 32'h99; acc_fill = 32'h9;
    @(negedge clk);
    snp_valid = 0; snp_kill = 0; tx_abort = 0; tx_commit = 0; acc_valid = 0; acc_write = 0;
    chk("R11 busy", 32'(busy), 1);
    chk("R11 same-cycle access dropped", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R11 conflict wins", 32'(abort_cause), 1);
    chk("R11 no commit", 32'(commit_done), 0);
    access(0, 0, 0, 16'h0009, 0, 32'h0);
    chk("R11 dropped access not allocated", 32'(r_hit), 0);
    start_tx(0, 32'h0);
    tx_abort = 1; tx_commit = 1;
    @(negedge clk);
    tx_abort = 0; tx_commit = 0;
    @(negedge clk);
    chk("R11 abort beats commit", 32'(abort_cause), 3);
    chk("R11 abort pulse", 32'(abort_done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mode();
    t_versions();
    t_abort();
    t_conflict();
    t_overflow();
    t_busy();
    t_regular();
    t_priority();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule